// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits between a byte-wide decoded transport stream and the pins that feed an external demultiplexer. It takes bytes through a valid/ready input, together with a per-packet flag saying whether the error corrector gave up on that packet. It sends them out as 204-byte packets: 188 payload bytes, then 16 parity bytes. Alongside the data bus it produces a byte clock, a packet clock that separates payload from parity, and an uncorrectable-packet flag. All of these are built from the internal system clock. Each output slot lasts `2*HALF_CYC` system clocks, and the active byte-clock edge falls in the middle of the slot.

The outputs can be parallel, with a whole byte on the bus per slot, or serial, with one bit per slot, MSB first, on bit 0. The active edge of the byte clock, the sense of the packet clock and the sense of the error flag can each be chosen. The byte clock can be silenced during parity. The pin drivers can be released to high impedance. Every setting except the release is captured when the first byte of a packet is taken, so a packet never changes format halfway through. The block counts packet position itself, so the first byte it accepts after reset, and every 204th byte after that, is the first byte of a packet.

Top module: `ts_out_formatter`

## Requirements
- R1: Every packet spans 204 byte positions. `ts_pclk` is 1 for positions 0 to 187 and 0 for positions 188 to 203; when the captured `cfg_pkt_inv` is 1 both levels are swapped.
- R2: `ts_err` equals the packet's `in_bad` value (captured with byte 0) on every byte of that packet; when the captured `cfg_err_inv` is 1 the level is swapped.
- R3: In a packet taken with `in_bad`=1, byte position 1 leaves the block with bit 7 set to 1. All other bytes leave unchanged.
- R4: In parallel mode (`cfg_serial`=0) each slot carries one byte on `ts_data[7:0]` and `ts_data_oe` is 8'hFF.
- R5: In serial mode (`cfg_serial`=1) each byte takes 8 consecutive slots, MSB first, on `ts_data[0]`, and `ts_data_oe` is 8'h01.
- R6: Each slot lasts 2*HALF_CYC system clocks. The data holds for the whole slot, and the active edge falls at clock HALF_CYC of the slot. With `cfg_clk_rise`=1 the active edge is a rising edge; with 0 it is a falling edge.
- R7: With the captured `cfg_mask_parity`=1, `ts_bclk` is held 0 throughout the parity positions, so no active edge marks them.
- R8: `cfg_hiz`=1 drives `ts_ctl_oe` and `ts_data_oe` to 0 in the same cycle, at any point in a packet. Clearing it restores them at once.
- R9: Mode, polarity and mask inputs are captured only when byte 0 of a packet is accepted. A change made partway through a packet does not alter that packet.
- R10: After reset `ts_bclk`=0, `ts_pclk`=1, `ts_err`=0, `ts_data_oe`=8'hFF, `ts_ctl_oe`=1 and `in_ready`=1.
- R11: When no input byte is waiting at a byte boundary, `ts_bclk` rests at 0 with no edges. The stream resumes with no byte lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_serial | input | 1 | 1: serial output on bit 0; 0: parallel |
| cfg_clk_rise | input | 1 | 1: data valid at rising byte-clock edge; 0: falling |
| cfg_pkt_inv | input | 1 | Swaps the packet clock levels |
| cfg_err_inv | input | 1 | Swaps the error flag levels |
| cfg_mask_parity | input | 1 | Holds the byte clock low during parity |
| cfg_hiz | input | 1 | Releases all output enables |
| in_valid | input | 1 | Input byte available |
| in_byte | input | BYTE_W | Input byte |
| in_bad | input | 1 | Packet uncorrectable, sampled with byte 0 |
| in_ready | output | 1 | Byte taken when high together with in_valid |
| ts_bclk | output | 1 | Byte (serial: bit) clock |
| ts_pclk | output | 1 | Packet clock, payload versus parity |
| ts_err | output | 1 | Uncorrectable-packet flag |
| ts_data | output | BYTE_W | Output data bus |
| ts_data_oe | output | BYTE_W | Per-bit drive enable for ts_data |
| ts_ctl_oe | output | 1 | Drive enable for ts_bclk, ts_pclk, ts_err |

## Verification
A byte-position counter that slips shows up as a packet-clock transition in the wrong place. In a marked packet it also shows up as bit 7 forced on the wrong byte. Both are visible at the first active edge after the slip. A bit counter or slot-phase counter that goes wrong moves or adds a byte-clock edge within one slot, so the demultiplexer captures a shifted or duplicated byte right away. Settings captured at the wrong time become visible at the next active edge after an input change made mid-packet. A stale error latch shows as a wrong flag on the first byte of the following packet.

// File: rtl/ts_fmt_pkg.sv
`timescale 1ns/1ps
package ts_fmt_pkg;

    // Settings captured at the start of each packet
    typedef struct packed {
        logic serial;
        logic clk_rise;
        logic pkt_inv;
        logic err_inv;
        logic mask_par;
    } ts_mode_t;

    typedef enum logic {
        SEG_DATA   = 1'b0,
        SEG_PARITY = 1'b1
    } ts_seg_e;

    // Byte-clock level for one cycle of a slot
    function automatic logic bclk_level(input logic active, input logic phase_hi,
                                        input logic rise, input logic masked);
        if (!active || masked)
            return 1'b0;
        return rise ? phase_hi : ~phase_hi;
    endfunction

endpackage

// File: rtl/ts_slot_timer.sv
`timescale 1ns/1ps
module ts_slot_timer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic slot_end,
    output logic phase_hi
);
    localparam int SLOT = 2 * HALF_CYC;
    localparam int PH_W = (SLOT > 1) ? $clog2(SLOT) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(HALF_CYC);

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst)
            ph <= '0;
        else if (start)
            ph <= '0;
        else if (run)
            ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
    end

    assign slot_end = run && (ph == PH_LAST);
    assign phase_hi = (ph >= PH_MID);

    // R6: a slot that is running and not restarted advances by exactly one phase step
    a_r6_phase_step: assert property (@(posedge clk) disable iff (rst)
        (run && !start && ph != PH_LAST) |=> (ph == $past(ph) + 1'b1));

endmodule

// File: rtl/ts_byte_seq.sv
`timescale 1ns/1ps
module ts_byte_seq
    import ts_fmt_pkg::*;
#(
    parameter int PKT_BYTES  = 204,
    parameter int DATA_BYTES = 188,
    parameter int BYTE_W     = 8,
    localparam int IDX_W     = $clog2(PKT_BYTES),
    localparam int BIT_W     = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  ts_mode_t          mode_in,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_bad,
    output logic              in_ready,
    input  logic              slot_end,
    output logic              load,
    output logic              active,
    output logic [IDX_W-1:0]  idx,
    output ts_seg_e           seg,
    output logic              bad_lat,
    output logic [BYTE_W-1:0] cur_byte,
    output ts_mode_t          mode_lat
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_BYTES);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] MSB_SET = {1'b1, {(BYTE_W-1){1'b0}}};

    logic [BIT_W-1:0] bitc;
    logic [IDX_W-1:0] nidx;
    logic             byte_done;
    logic             mark;

    assign byte_done = slot_end && (!mode_lat.serial || bitc == BIT_LAST);
    assign nidx      = byte_done ? ((idx == IDX_LAST) ? '0 : idx + 1'b1) : idx;
    assign in_ready  = !active || byte_done;
    assign load      = in_valid && in_ready;
    assign mark      = (nidx == IDX_W'(1)) && bad_lat;
    assign seg       = (idx < IDX_DATA) ? SEG_DATA : SEG_PARITY;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            idx      <= '0;
            bitc     <= '0;
            cur_byte <= '0;
            mode_lat <= '0;
            bad_lat  <= 1'b0;
        end else begin
            idx <= nidx;
            if (byte_done && idx == IDX_LAST)
                bad_lat <= 1'b0;
            if (load) begin
                active   <= 1'b1;
                bitc     <= '0;
                cur_byte <= mark ? (in_byte | MSB_SET) : in_byte;
                if (nidx == '0) begin
                    mode_lat <= mode_in;
                    bad_lat  <= in_bad;
                end
            end else if (byte_done) begin
                active <= 1'b0;
            end else if (slot_end) begin
                bitc     <= bitc + 1'b1;
                cur_byte <= cur_byte << 1;
            end
        end
    end

    // R9: captured settings hold everywhere except across a packet start
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
        (idx != '0 && idx != IDX_LAST) |=> $stable(mode_lat));

    // R3: the second byte of a marked packet is loaded with its top bit set
    a_r3_mark_msb: assert property (@(posedge clk) disable iff (rst)
        (load && nidx == IDX_W'(1) && bad_lat) |=> cur_byte[BYTE_W-1]);

    // R5: the bit counter only moves in serial mode
    a_r5_bits_parallel_idle: assert property (@(posedge clk) disable iff (rst)
        !mode_lat.serial |-> (bitc == '0));

endmodule

// File: rtl/ts_pin_map.sv
`timescale 1ns/1ps
module ts_pin_map
    import ts_fmt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              active,
    input  logic              phase_hi,
    input  ts_seg_e           seg,
    input  logic              bad_lat,
    input  logic [BYTE_W-1:0] cur_byte,
    input  ts_mode_t          mode_lat,
    input  logic              hiz,
    output logic              ts_bclk,
    output logic              ts_pclk,
    output logic              ts_err,
    output logic [BYTE_W-1:0] ts_data,
    output logic [BYTE_W-1:0] ts_data_oe,
    output logic              ts_ctl_oe
);
    logic masked;

    assign masked    = mode_lat.mask_par && (seg == SEG_PARITY);
    assign ts_bclk   = bclk_level(active, phase_hi, mode_lat.clk_rise, masked);
    assign ts_pclk   = (seg == SEG_DATA) ^ mode_lat.pkt_inv;
    assign ts_err    = bad_lat ^ mode_lat.err_inv;
    assign ts_ctl_oe = !hiz;

    genvar gi;
    generate
        for (gi = 0; gi < BYTE_W; gi++) begin : g_lane
            if (gi == 0) begin : g_serial_lane
                assign ts_data[gi]    = mode_lat.serial ? cur_byte[BYTE_W-1] : cur_byte[gi];
                assign ts_data_oe[gi] = !hiz;
            end else begin : g_par_lane
                assign ts_data[gi]    = mode_lat.serial ? 1'b0 : cur_byte[gi];
                assign ts_data_oe[gi] = !hiz && !mode_lat.serial;
            end
        end
    endgenerate

endmodule

// File: rtl/ts_out_formatter.sv
`timescale 1ns/1ps
module ts_out_formatter
    import ts_fmt_pkg::*;
#(
    parameter int PKT_BYTES  = 204,
    parameter int DATA_BYTES = 188,
    parameter int BYTE_W     = 8,
    parameter int HALF_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_serial,
    input  logic              cfg_clk_rise,
    input  logic              cfg_pkt_inv,
    input  logic              cfg_err_inv,
    input  logic              cfg_mask_parity,
    input  logic              cfg_hiz,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_bad,
    output logic              in_ready,
    output logic              ts_bclk,
    output logic              ts_pclk,
    output logic              ts_err,
    output logic [BYTE_W-1:0] ts_data,
    output logic [BYTE_W-1:0] ts_data_oe,
    output logic              ts_ctl_oe
);
    localparam int IDX_W = $clog2(PKT_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_BYTES - 1);

    ts_mode_t          mode_in;
    ts_mode_t          mode_lat;
    ts_seg_e           seg;
    logic              load;
    logic              active;
    logic              slot_end;
    logic              phase_hi;
    logic              bad_lat;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] cur_byte;

    assign mode_in = '{serial:   cfg_serial,
                       clk_rise: cfg_clk_rise,
                       pkt_inv:  cfg_pkt_inv,
                       err_inv:  cfg_err_inv,
                       mask_par: cfg_mask_parity};

    ts_slot_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (load),
        .run      (active),
        .slot_end (slot_end),
        .phase_hi (phase_hi)
    );

    ts_byte_seq #(
        .PKT_BYTES  (PKT_BYTES),
        .DATA_BYTES (DATA_BYTES),
        .BYTE_W     (BYTE_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (mode_in),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_bad   (in_bad),
        .in_ready (in_ready),
        .slot_end (slot_end),
        .load     (load),
        .active   (active),
        .idx      (idx),
        .seg      (seg),
        .bad_lat  (bad_lat),
        .cur_byte (cur_byte),
        .mode_lat (mode_lat)
    );

    ts_pin_map #(.BYTE_W(BYTE_W)) u_pins (
        .active     (active),
        .phase_hi   (phase_hi),
        .seg        (seg),
        .bad_lat    (bad_lat),
        .cur_byte   (cur_byte),
        .mode_lat   (mode_lat),
        .hiz        (cfg_hiz),
        .ts_bclk    (ts_bclk),
        .ts_pclk    (ts_pclk),
        .ts_err     (ts_err),
        .ts_data    (ts_data),
        .ts_data_oe (ts_data_oe),
        .ts_ctl_oe  (ts_ctl_oe)
    );

    // R11: with no byte in flight the byte clock rests low
    a_r11_idle_low: assert property (@(posedge clk) disable iff (rst)
        !active |-> !ts_bclk);

    // R7: masked parity positions show no byte-clock high level
    a_r7_mask_low: assert property (@(posedge clk) disable iff (rst)
        (mode_lat.mask_par && seg == SEG_PARITY) |-> !ts_bclk);

    // R2: the error flag cannot move inside a packet
    a_r2_err_steady: assert property (@(posedge clk) disable iff (rst)
        (idx != '0 && idx != IDX_LAST) |=> $stable(ts_err));

endmodule

// File: tb/tb_ts_out_formatter.sv
`timescale 1ns/1ps
module tb_ts_out_formatter;

    localparam int HALF = 2;
    localparam int PKT  = 204;
    localparam int DAT  = 188;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic c_serial = 0, c_rise = 0, c_pinv = 0, c_einv = 0, c_mask = 0, c_hiz = 0;
    logic n_serial = 0, n_rise = 0, n_pinv = 0, n_einv = 0, n_mask = 0;
    logic       in_valid = 0;
    logic [7:0] in_byte  = '0;
    logic       in_bad   = 0;
    logic       in_ready, ts_bclk, ts_pclk, ts_err, ts_ctl_oe;
    logic [7:0] ts_data, ts_data_oe;

    ts_out_formatter #(.PKT_BYTES(PKT), .DATA_BYTES(DAT), .BYTE_W(8), .HALF_CYC(HALF)) dut (
        .clk(clk), .rst(rst),
        .cfg_serial(c_serial), .cfg_clk_rise(c_rise), .cfg_pkt_inv(c_pinv),
        .cfg_err_inv(c_einv), .cfg_mask_parity(c_mask), .cfg_hiz(c_hiz),
        .in_valid(in_valid), .in_byte(in_byte), .in_bad(in_bad), .in_ready(in_ready),
        .ts_bclk(ts_bclk), .ts_pclk(ts_pclk), .ts_err(ts_err),
        .ts_data(ts_data), .ts_data_oe(ts_data_oe), .ts_ctl_oe(ts_ctl_oe)
    );

    typedef struct {
        logic [7:0] b;
        logic       pk;
        logic       er;
        logic       ser;
        logic       rise;
        logic       chg;
        int         idx;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per byte seen at the active edge
    logic       prev_b = 0;
    logic       last_rise = 0;
    logic       cur_rise;
    logic       edge_seen;
    int         nbit = 0;
    logic [7:0] acc = '0;
    item_t      it;
    string      tag;

    always @(negedge clk) begin
        if (rst) begin
            prev_b = 0; last_rise = 0; nbit = 0;
        end else begin
            cur_rise  = (q.size() > 0) ? q[0].rise : last_rise;
            edge_seen = cur_rise ? (ts_bclk && !prev_b) : (!ts_bclk && prev_b);
            if (edge_seen) begin
                if (q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R6 unexpected active edge actual=1 expected=0");
                end else begin
                    if (q[0].ser) begin
                        acc = {acc[6:0], ts_data[0]}; nbit++;
                    end else begin
                        acc = ts_data; nbit = 8;
                    end
                    if (nbit == 8) begin
                        it = q.pop_front();
                        last_rise = it.rise;
                        nbit = 0;
                        tag = $sformatf("%s byte %0d%s%s (R6 %s edge)",
                                        it.ser ? "R5 serial" : "R4 parallel", it.idx,
                                        (it.idx == 1) ? " R3" : "", it.chg ? " R9" : "",
                                        it.rise ? "rising" : "falling");
                        chk(tag, {24'd0, acc}, {24'd0, it.b});
                        chk($sformatf("R1 packet clock byte %0d%s", it.idx, it.chg ? " R9" : ""),
                            {31'd0, ts_pclk}, {31'd0, it.pk});
                        chk($sformatf("R2 error flag byte %0d", it.idx),
                            {31'd0, ts_err}, {31'd0, it.er});
                        if (!c_hiz)
                            chk(it.ser ? "R5 data enables" : "R4 data enables",
                                {24'd0, ts_data_oe}, it.ser ? 32'h01 : 32'hff);
                    end
                end
            end
            prev_b = ts_bclk;
        end
    end

    task automatic apply_next();
        c_serial = n_serial; c_rise = n_rise; c_pinv = n_pinv;
        c_einv = n_einv; c_mask = n_mask;
    endtask

    // Driver: feeds one packet and pushes the bytes the pins must show
    task automatic send_packet(input logic bad, input int seed, input int chg_at, input int gap_at);
        logic ser  = c_serial;
        logic rise = c_rise;
        logic pinv = c_pinv;
        logic einv = c_einv;
        logic msk  = c_mask;
        item_t e;
        for (int i = 0; i < PKT; i++) begin
            logic [7:0] b;
            b = (i == 0) ? 8'h47 : 8'(seed * 37 + i * 13 + (i >> 3));
            if (i == 1) b = b & 8'h7f;
            if (i == chg_at) apply_next();
            if (!(msk && i >= DAT)) begin
                e.b    = (i == 1 && bad) ? (b | 8'h80) : b;
                e.pk   = (i < DAT) ^ pinv;
                e.er   = bad ^ einv;
                e.ser  = ser;
                e.rise = rise;
                e.chg  = (chg_at >= 0);
                e.idx  = i;
                q.push_back(e);
            end
            @(negedge clk);
            in_valid = 1; in_byte = b; in_bad = bad;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1 in_valid = 0;
            if (i == gap_at) begin
                repeat (40) @(negedge clk);
                chk("R11 byte clock at rest during input gap", {31'd0, ts_bclk}, 32'd0);
            end
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        // R10 reset state
        chk("R10 bclk after reset", {31'd0, ts_bclk}, 32'd0);
        chk("R10 pclk after reset", {31'd0, ts_pclk}, 32'd1);
        chk("R10 err after reset", {31'd0, ts_err}, 32'd0);
        chk("R10 data enables after reset", {24'd0, ts_data_oe}, 32'hff);
        chk("R10 control enable after reset", {31'd0, ts_ctl_oe}, 32'd1);
        chk("R10 ready after reset", {31'd0, in_ready}, 32'd1);

        // R4 parallel, falling edge, clean then marked packet (R1, R2, R3)
        send_packet(1'b0, 1, -1, -1);
        send_packet(1'b1, 2, -1, -1);

        // R9: settings change partway through; packet keeps the old format
        n_serial = 0; n_rise = 1; n_pinv = 1; n_einv = 1; n_mask = 0;
        send_packet(1'b0, 3, 100, -1);
        // R6 rising edge with inverted packet clock and flag, marked packet
        send_packet(1'b1, 4, -1, -1);

        // R7 masked parity plus R11 input gap
        c_rise = 0; c_pinv = 0; c_einv = 0; c_mask = 1;
        send_packet(1'b0, 5, -1, 50);

        // R5 serial, marked, with an R8 release pulse in the middle
        c_serial = 1; c_mask = 0;
        fork
            send_packet(1'b1, 6, -1, -1);
            begin
                repeat (500) @(posedge clk);
                #1 c_hiz = 1;
                #0.5;
                chk("R8 control enable released mid-packet", {31'd0, ts_ctl_oe}, 32'd0);
                chk("R8 data enables released mid-packet", {24'd0, ts_data_oe}, 32'd0);
                @(posedge clk);
                #1 c_hiz = 0;
                #0.5;
                chk("R8 control enable restored", {31'd0, ts_ctl_oe}, 32'd1);
            end
        join

        // R5 serial on rising edge with an R11 gap
        c_rise = 1;
        send_packet(1'b0, 7, -1, 3);

        for (int k = 0; k < 4000 && q.size() > 0; k++) @(negedge clk);
        chk("R1 every expected byte delivered", q.size(), 32'd0);

        // R8 while idle
        @(negedge clk) c_hiz = 1;
        #1;
        chk("R8 control enable released when idle", {31'd0, ts_ctl_oe}, 32'd0);
        chk("R8 data enables released when idle", {24'd0, ts_data_oe}, 32'd0);
        @(negedge clk) c_hiz = 0;
        #1;
        chk("R8 serial data enable restored", {24'd0, ts_data_oe}, 32'h01);
        chk("R11 byte clock at rest after stream", {31'd0, ts_bclk}, 32'd0);

        finish_run();
    end

endmodule